// File: doc/BRIEF.md
# Masked Shuffled Coefficient Multiplier

This block forms the coefficient-wise product of a secret polynomial and a public polynomial over the integers mod q = 3329, with N = 256 coefficients per polynomial. The secret arrives as two additive shares, and the block keeps them apart from input to output. Each share is multiplied by the public coefficient, reduced, and then re-masked with a fresh random value before it is emitted. The two output shares add up mod q to the true product, and neither share on its own equals the product.

Three internal coefficient memories hold share 0, share 1 and the public operand, and a simple write port fills them. A start pulse launches a run. The block first builds a random visiting order of the N indices with an in-place swap shuffle. It then processes one coefficient per slot in that order and streams each result out with its index. Every shuffle step and every multiply slot takes exactly one word from a valid/ready randomness port. When no word is offered, the whole schedule stops for that cycle. Run length therefore depends only on how long the randomness source stalls, never on the data or on the random values.

Top module: `masked_shuffle_mul`

## Requirements
- R1: After reset, busy, done, out_valid and rnd_ready are all low.
- R2: A write with ld_en high stores ld_data at ld_addr in memory ld_sel, where 0 selects share 0, 1 selects share 1 and 2 selects the public operand. Stored values lie in [0, q).
- R3: When start is sampled while idle, the order table is set to the identity. The block then takes N-1 random words, for i = N-1 down to 1. For each word w it computes j = (w[15:0] * (i+1)) >> 16 and swaps table entries i and j.
- R4: The multiply phase has N slots, k = 0 to N-1, each taking one random word. Slot k raises out_valid for one cycle with out_idx equal to table entry k, so every index appears exactly once.
- R5: For slot k, with index x and word w, r = (w[31:16] * q) >> 16 and out_sh0 = (share0[x] * pub[x] mod q + r) mod q.
- R6: For the same slot, out_sh1 = (share1[x] * pub[x] mod q - r) mod q. As a result, (out_sh0 + out_sh1) mod q = (share0 + share1) * pub mod q.
- R7: Both output shares are always in [0, q), including when every input coefficient is q-1.
- R8: rnd_ready is high only during the shuffle and multiply phases. A cycle with rnd_ready high and rnd_valid low advances nothing. done rises 2N clock edges after the edge that samples start, plus one edge for each such stalled cycle.
- R9: done is a single-cycle pulse that coincides with the last out_valid. A start pulse while busy is ignored and leaves the timing and the outputs unchanged.
- R10: Two runs fed with different random words visit different index orders but take the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Coefficient write strobe |
| ld_sel | input | 2 | Target memory: 0 share 0, 1 share 1, 2 public |
| ld_addr | input | 8 | Coefficient index to write |
| ld_data | input | 12 | Coefficient value, in [0, q) |
| start | input | 1 | Start pulse, honoured only while idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rnd_valid | input | 1 | Random word offered |
| rnd_ready | output | 1 | Block consumes a word this cycle if valid |
| rnd_data | input | 32 | Random word |
| out_valid | output | 1 | Output shares valid |
| out_idx | output | 8 | Coefficient index of this output |
| out_sh0 | output | 12 | Output share 0 |
| out_sh1 | output | 12 | Output share 1 |

## Verification
Random coefficients and random words are checked exactly against a bench model of the shuffle and the refresh, which separates a wrong permutation from a wrong product or a wrong mask. All-maximum coefficients stress the reduction at its upper bound, and all-zero coefficients show that the output shares carry only the mask. Runs with a random stall pattern test that stalls stretch the timing by exactly one cycle each. A second run with fresh randomness must visit the indices in a different order in the same number of cycles. A start pulse in mid-run must change nothing.

// File: rtl/masked_shuffle_mul.sv
module masked_shuffle_mul #(
  parameter int N  = 256,
  parameter int Q  = 3329,
  parameter int CW = 12,
  parameter int RW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_en,
  input  logic [1:0]             ld_sel,
  input  logic [$clog2(N)-1:0]   ld_addr,
  input  logic [CW-1:0]          ld_data,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  input  logic                   rnd_valid,
  output logic                   rnd_ready,
  input  logic [RW-1:0]          rnd_data,
  output logic                   out_valid,
  output logic [$clog2(N)-1:0]   out_idx,
  output logic [CW-1:0]          out_sh0,
  output logic [CW-1:0]          out_sh1
);
  localparam int AW = $clog2(N);
  localparam int RH = RW / 2;
  localparam int PW = 2 * CW;
  localparam int BK = 2 * CW + 2;
  localparam int MW = BK - CW + 2;
  localparam int XW = PW + MW;
  localparam int JW = RH + AW + 1;
  localparam int FW = RH + CW;
  localparam logic [MW-1:0] MC = MW'((1 << BK) / Q);
  localparam logic [CW:0]   QW = (CW+1)'(Q);
  localparam logic [PW-1:0] QP = PW'(Q);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_SHUF, S_MUL} st_t;

  st_t st;
  logic [AW-1:0] cnt;
  logic [AW-1:0] perm [N];
  logic [CW-1:0] mem0 [N];
  logic [CW-1:0] mem1 [N];
  logic [CW-1:0] memb [N];

  function automatic logic [CW-1:0] fold(input logic [CW:0] v);
    logic [CW:0] s;
    s = v - QW;
    return (s[CW-1:0] & ~{CW{s[CW]}}) | (v[CW-1:0] & {CW{s[CW]}});
  endfunction

  function automatic logic [CW-1:0] modmul(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [PW-1:0] x, t, d;
    logic [XW-1:0] xm;
    x  = PW'(a) * PW'(b);
    xm = XW'(x) * XW'(MC);
    t  = PW'(xm >> BK);
    d  = x - t * QP;
    return fold(d[CW:0]);
  endfunction

  assign busy      = (st != S_IDLE);
  assign rnd_ready = (st == S_SHUF) || (st == S_MUL);
  wire adv = rnd_ready && rnd_valid;

  wire [JW-1:0]   jprod = JW'(rnd_data[RH-1:0]) * JW'({1'b0, cnt} + 1'b1);
  wire [AW-1:0]   jsel  = jprod[RH +: AW];
  wire [FW-1:0]   rprod = FW'(rnd_data[RW-1:RH]) * FW'(Q);
  wire [CW-1:0]   rmask = rprod[RH +: CW];

  wire [AW-1:0]   idx = perm[cnt];
  wire [CW-1:0]   p0  = modmul(mem0[idx], memb[idx]);
  wire [CW-1:0]   p1  = modmul(mem1[idx], memb[idx]);
  wire [CW-1:0]   o0  = fold({1'b0, p0} + {1'b0, rmask});
  wire [CW:0]     dv  = {1'b0, p1} - {1'b0, rmask};
  wire [CW:0]     dc  = dv + (QW & {(CW+1){dv[CW]}});

  always_ff @(posedge clk) begin
    if (ld_en) begin
      if (ld_sel == 2'd0) mem0[ld_addr] <= ld_data;
      if (ld_sel == 2'd1) mem1[ld_addr] <= ld_data;
      if (ld_sel == 2'd2) memb[ld_addr] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_INIT) begin
      for (int i = 0; i < N; i++) perm[i] <= AW'(i);
    end else if (st == S_SHUF && adv) begin
      perm[cnt]  <= perm[jsel];
      perm[jsel] <= perm[cnt];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_sh0   <= '0;
      out_sh1   <= '0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) st <= S_INIT;
        S_INIT: begin
          st  <= S_SHUF;
          cnt <= AW'(N - 1);
        end
        S_SHUF: if (adv) begin
          if (cnt == AW'(1)) begin
            st  <= S_MUL;
            cnt <= '0;
          end else cnt <= cnt - 1'b1;
        end
        S_MUL: if (adv) begin
          out_valid <= 1'b1;
          out_idx   <= idx;
          out_sh0   <= o0;
          out_sh1   <= dc[CW-1:0];
          if (cnt == AW'(N - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_ready |-> busy);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_ready && !rnd_valid) |=> ($stable(cnt) && $stable(st) && !out_valid));
  p_out_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sh0 < CW'(Q) && out_sh1 < CW'(Q)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && !busy));
  p_out_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_ready && rnd_valid && !$past(rnd_ready)) |-> !out_valid);
endmodule

// File: tb/masked_shuffle_mul_tb.sv
module masked_shuffle_mul_tb;
  localparam int N = 256;
  localparam int Q = 3329;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [1:0] ld_sel = '0;
  logic [7:0] ld_addr = '0;
  logic [11:0] ld_data = '0;
  logic start = 1'b0;
  logic busy, done, rnd_ready, out_valid;
  logic rnd_valid = 1'b0;
  logic [31:0] rnd_data = '0;
  logic [7:0] out_idx;
  logic [11:0] out_sh0, out_sh1;

  always #10 clk = ~clk;

  masked_shuffle_mul u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .start(start), .busy(busy), .done(done),
    .rnd_valid(rnd_valid), .rnd_ready(rnd_ready), .rnd_data(rnd_data),
    .out_valid(out_valid), .out_idx(out_idx), .out_sh0(out_sh0), .out_sh1(out_sh1));

  int checks = 0;
  int failures = 0;
  int a0 [N];
  int a1 [N];
  int bp [N];
  int words [2*N];
  int nw;
  int g_idx [N];
  int g_s0 [N];
  int g_s1 [N];
  int ng;
  int prev_order [N];
  int cycles, stalls;
  bit hung;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int mode);
    for (int i = 0; i < N; i++) begin
      a0[i] = (mode == 1) ? Q-1 : (mode == 2) ? 0 : int'($urandom % Q);
      a1[i] = (mode == 1) ? Q-1 : (mode == 2) ? 0 : int'($urandom % Q);
      bp[i] = (mode == 1) ? Q-1 : (mode == 2) ? 0 : int'($urandom % Q);
    end
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < N; i++) begin
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'(s); ld_addr = 8'(i);
        ld_data = 12'((s == 0) ? a0[i] : (s == 1) ? a1[i] : bp[i]);
      end
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input int stall_pct, input bit mid_start);
    nw = 0; ng = 0; cycles = 0; stalls = 0; hung = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    forever begin
      if (out_valid && ng < N) begin
        g_idx[ng] = out_idx; g_s0[ng] = out_sh0; g_s1[ng] = out_sh1; ng++;
      end
      if (done) break;
      if (cycles > 4000) begin hung = 1; break; end
      start = mid_start && (cycles == 100);
      rnd_valid = (int'($urandom % 100) >= stall_pct);
      rnd_data = $urandom;
      if (rnd_ready && rnd_valid && nw < 2*N) begin words[nw] = int'(rnd_data); nw++; end
      if (rnd_ready && !rnd_valid) stalls++;
      @(negedge clk);
      cycles++;
    end
    start = 1'b0; rnd_valid = 1'b0;
    chk(!hung, "R8 watchdog", cycles, 2*N);
    @(negedge clk);
    chk(!done && !busy, "R9 done pulse width", int'(done), 0);
  endtask

  task automatic verify();
    int ord [N];
    int seen [N];
    int tmp, j, w, r, p0, p1;
    chk(cycles == 2*N + stalls, "R8 latency", cycles, 2*N + stalls);
    chk(ng == N, "R4 slot count", ng, N);
    chk(nw == 2*N-1, "R3 words used", nw, 2*N-1);
    for (int i = 0; i < N; i++) begin ord[i] = i; seen[i] = 0; end
    for (int i = N-1; i >= 1; i--) begin
      w = words[N-1-i];
      j = ((w & 32'hFFFF) * (i+1)) >>> 16;
      tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
    end
    for (int k = 0; k < ng; k++) begin
      int x;
      x = g_idx[k];
      seen[x]++;
      chk(x == ord[k], "R3 R4 visit order", x, ord[k]);
      w = words[N-1+k];
      r = int'(((longint'(w) >>> 16 & 64'hFFFF) * Q) >>> 16);
      p0 = (a0[x] * bp[x]) % Q;
      p1 = (a1[x] * bp[x]) % Q;
      chk(g_s0[k] == (p0 + r) % Q, "R5 R2 share0", g_s0[k], (p0 + r) % Q);
      chk(g_s1[k] == (p1 - r + Q) % Q, "R6 share1", g_s1[k], (p1 - r + Q) % Q);
      chk(g_s0[k] < Q && g_s1[k] < Q, "R7 range", g_s0[k], Q-1);
      chk((g_s0[k] + g_s1[k]) % Q == ((a0[x] + a1[x]) * bp[x]) % Q, "R6 recombine",
          (g_s0[k] + g_s1[k]) % Q, ((a0[x] + a1[x]) * bp[x]) % Q);
    end
    for (int i = 0; i < N; i++) chk(seen[i] == 1, "R4 each index once", seen[i], 1);
  endtask

  initial begin
    int diff, base;
    void'($urandom(32'd20240611));
    #5;
    chk(!busy && !done && !out_valid && !rnd_ready, "R1 reset outputs",
        int'({busy, done, out_valid, rnd_ready}), 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !out_valid && !rnd_ready, "R1 reset held",
        int'({busy, done, out_valid, rnd_ready}), 0);
    rst_n = 1'b1;

    load(0);
    run(0, 1'b0);
    verify();
    base = cycles;
    for (int i = 0; i < N; i++) prev_order[i] = g_idx[i];

    run(0, 1'b0);
    verify();
    diff = 0;
    for (int i = 0; i < N; i++) if (prev_order[i] != g_idx[i]) diff++;
    chk(diff > 0, "R10 orders differ", diff, 1);
    chk(cycles == base, "R10 equal cycles", cycles, base);

    run(0, 1'b1);
    verify();
    chk(cycles == base, "R9 mid-run start ignored", cycles, base);

    run(30, 1'b0);
    verify();
    chk(stalls > 0, "R8 stalls occurred", stalls, 1);

    load(1);
    run(0, 1'b0);
    verify();

    load(2);
    run(10, 1'b0);
    verify();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule